// File: doc/BRIEF.md
# Floating-point predicate compare unit

This unit compares two IEEE-754 values and reduces the outcome to a single condition flag. A format input selects the precision. When it is low, both operands are single precision and are taken from the low 32 bits of the 64-bit operand ports. When it is high, both operands are double precision. The operand pair is first classified as less, equal, greater or unordered. A 3-bit condition code then picks one of eight predicates over that class, and the predicate's truth value becomes the flag.

The flag is merged into a 32-bit status/control word supplied by the caller. The merged word is returned with the flag at bit 29, bits 31, 30 and 28 cleared, and bits 27:0 passed through unchanged. The compare is quiet: quiet NaNs only make the pair unordered. A signaling NaN in either operand also raises an invalid-operation output.

All results are registered. They appear one cycle after a valid input, together with a matching valid output.

Top module: `fp_cmp_pred`

## Requirements
- R1: The condition code selects the predicate as follows: 0 never true; 1 unordered; 2 equal; 3 unordered or equal; 4 less (ordered); 5 less or unordered; 6 less or equal (ordered); 7 anything but greater.
- R2: The class output encodes the pair as 0 = less, 1 = equal, 2 = greater, 3 = unordered. A NaN is an operand whose exponent is all ones and whose fraction is non-zero. Any NaN operand makes the class unordered.
- R3: Positive zero and negative zero compare equal, in both formats.
- R4: Code 0 always gives flag 0. Code 7 gives flag 1 for every class except greater.
- R5: The returned status word carries the flag at bit 29, has bits 31, 30 and 28 at 0, and equals the input status word in bits 27:0.
- R6: The invalid output is 1 only when an operand is a signaling NaN, meaning a NaN whose most significant fraction bit is 0. Quiet NaNs (that fraction bit is 1) leave it at 0.
- R7: With the format input low, bits 63:32 of both operand ports have no effect on any output. The same predicate table applies to both formats.
- R8: All outputs are registered. The valid output is the valid input delayed by one cycle. The other outputs update only on cycles with a valid input, and all outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single (low 32 bits) |
| cond | input | 3 | Predicate code |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| stat_in | input | 32 | Previous status/control word |
| out_valid | output | 1 | Results below are fresh this cycle |
| flag_out | output | 1 | Predicate result |
| rel_out | output | 2 | Class of the pair (R2 encoding) |
| invalid_out | output | 1 | Signaling NaN seen |
| stat_out | output | 32 | Merged status word |

## Verification
The unit is driven with directed pairs that isolate each class: mixed-sign values, same-sign negative values where the magnitude order reverses, signed zeros, infinities, and quiet and signaling NaNs in each operand slot. Every directed pair is run under all eight codes, so any misplaced predicate column shows up. A long run of random operands, formats, codes and status words follows. In single format, garbage is placed in the upper operand bits to separate true single-precision decoding from accidental use of the upper half. Idle cycles between valid ones show whether the outputs hold their values.

// File: rtl/fp_cmp_pred.sv
module fp_cmp_pred #(
  parameter int FLAG_BIT = 29
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        fmt_dbl,
  input  logic [2:0]  cond,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic [31:0] stat_in,
  output logic        out_valid,
  output logic        flag_out,
  output logic [1:0]  rel_out,
  output logic        invalid_out,
  output logic [31:0] stat_out
);
  localparam logic [1:0] REL_LT = 2'd0, REL_EQ = 2'd1, REL_GT = 2'd2, REL_UN = 2'd3;

  logic        sgn_a, sgn_b, nan_a, nan_b, snan_a, snan_b, both_zero;
  logic [62:0] mag_a, mag_b;
  logic [1:0]  rel;
  logic        flag;

  assign sgn_a = fmt_dbl ? op_a[63] : op_a[31];
  assign sgn_b = fmt_dbl ? op_b[63] : op_b[31];
  assign mag_a = fmt_dbl ? op_a[62:0] : {32'd0, op_a[30:0]};
  assign mag_b = fmt_dbl ? op_b[62:0] : {32'd0, op_b[30:0]};

  assign nan_a = fmt_dbl ? (&op_a[62:52] && |op_a[51:0]) : (&op_a[30:23] && |op_a[22:0]);
  assign nan_b = fmt_dbl ? (&op_b[62:52] && |op_b[51:0]) : (&op_b[30:23] && |op_b[22:0]);
  assign snan_a = nan_a && !(fmt_dbl ? op_a[51] : op_a[22]);
  assign snan_b = nan_b && !(fmt_dbl ? op_b[51] : op_b[22]);
  assign both_zero = (mag_a == '0) && (mag_b == '0);

  always_comb begin
    if (nan_a || nan_b)            rel = REL_UN;
    else if (both_zero)            rel = REL_EQ;
    else if (sgn_a != sgn_b)       rel = sgn_a ? REL_LT : REL_GT;
    else if (mag_a == mag_b)       rel = REL_EQ;
    else if ((mag_a < mag_b) ^ sgn_a) rel = REL_LT;
    else                           rel = REL_GT;
  end

  assign flag = (cond[2] && rel == REL_LT) || (cond[1] && rel == REL_EQ) ||
                (cond[0] && rel == REL_UN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      flag_out    <= 1'b0;
      rel_out     <= 2'd0;
      invalid_out <= 1'b0;
      stat_out    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        flag_out    <= flag;
        rel_out     <= rel;
        invalid_out <= snan_a || snan_b;
        stat_out    <= {2'b00, flag, 1'b0, stat_in[27:0]};
      end
    end
  end

  // R8
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(stat_out) && $stable(flag_out));
  // R4
  code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 3'd0) |=> !flag_out);
  // R5
  stat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (stat_out[31:30] == 2'b00 && !stat_out[28] && stat_out[FLAG_BIT] == flag_out));
  // R5
  stat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> stat_out[27:0] == $past(stat_in[27:0]));
  // R6
  invalid_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && invalid_out) |-> rel_out == REL_UN);
  // R4
  code_seven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 3'd7) |=> (flag_out == (rel_out != REL_GT)));
endmodule

// File: tb/sim_fp_cmp_pred.sv
module sim_fp_cmp_pred;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, fmt_dbl = 1'b0;
  logic [2:0] cond = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [31:0] stat_in = '0;
  logic out_valid, flag_out, invalid_out;
  logic [1:0] rel_out;
  logic [31:0] stat_out;

  int total = 0, bad = 0;
  logic e_valid = 0, e_flag = 0, e_inv = 0;
  logic [1:0] e_rel = 0;
  logic [31:0] e_stat = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fp_cmp_pred u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
    .cond(cond), .op_a(op_a), .op_b(op_b), .stat_in(stat_in), .out_valid(out_valid),
    .flag_out(flag_out), .rel_out(rel_out), .invalid_out(invalid_out), .stat_out(stat_out));

  function automatic bit is_nan(bit dbl, logic [63:0] x);
    if (dbl) return x[62:52] == 11'h7ff && x[51:0] != 0;
    return x[30:23] == 8'hff && x[22:0] != 0;
  endfunction

  function automatic bit is_snan(bit dbl, logic [63:0] x);
    return is_nan(dbl, x) && (dbl ? x[51] == 0 : x[22] == 0);
  endfunction

  function automatic longint key(bit dbl, logic [63:0] x);
    longint m;
    m = dbl ? longint'({1'b0, x[62:0]}) : longint'(x[30:0]);
    return (dbl ? x[63] : x[31]) ? -m : m;
  endfunction

  function automatic int ref_rel(bit dbl, logic [63:0] a, logic [63:0] b);
    longint ka, kb;
    if (is_nan(dbl, a) || is_nan(dbl, b)) return 3;
    ka = key(dbl, a); kb = key(dbl, b);
    if (ka < kb) return 0;
    if (ka == kb) return 1;
    return 2;
  endfunction

  function automatic bit ref_pred(int c, int r);
    case (c)
      0: return 0;
      1: return r == 3;
      2: return r == 1;
      3: return r == 1 || r == 3;
      4: return r == 0;
      5: return r == 0 || r == 3;
      6: return r == 0 || r == 1;
      default: return r != 2;
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(out_valid === e_valid, "R8 out_valid", out_valid, e_valid);
    check(flag_out === e_flag, "R1 flag", flag_out, e_flag);
    check(rel_out === e_rel, "R2 class", rel_out, e_rel);
    check(invalid_out === e_inv, "R6 invalid", invalid_out, e_inv);
    check(stat_out === e_stat, "R5 status", stat_out, e_stat);
  endtask

  task automatic step(input bit v, input bit dbl, input int c, input logic [63:0] a,
                      input logic [63:0] b, input logic [31:0] s);
    int r;
    in_valid = v; fmt_dbl = dbl; cond = 3'(c); op_a = a; op_b = b; stat_in = s;
    e_valid = v;
    if (v) begin
      r = ref_rel(dbl, a, b);
      e_rel = 2'(r);
      e_flag = ref_pred(c, r);
      e_inv = is_snan(dbl, a) || is_snan(dbl, b);
      e_stat = {s[31:30], e_flag, s[28], s[27:0]};
      e_stat[31:30] = 2'b00; e_stat[28] = 1'b0;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic all_codes(input bit dbl, input logic [63:0] a, input logic [63:0] b);
    for (int c = 0; c < 8; c++) step(1, dbl, c, a, b, 32'hF5A5_5A5A ^ 32'(c));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ra, rb;
    logic [63:0] sp[8];
    sp[0] = 64'h0; sp[1] = 64'h8000_0000; sp[2] = 64'h7F80_0000; sp[3] = 64'h7FC0_0000;
    sp[4] = 64'h7F80_0001; sp[5] = 64'h3F80_0000; sp[6] = 64'hBF80_0000; sp[7] = 64'hFF80_0000;
    repeat (3) @(negedge clk);
    // R8 reset state
    compare_all();
    rst_n = 1;
    @(negedge clk);
    // R1 R2 single: less, greater, negative reversal
    all_codes(0, 64'h3F80_0000, 64'h4000_0000);
    all_codes(0, 64'h4000_0000, 64'hBF80_0000);
    all_codes(0, 64'hC000_0000, 64'hBF80_0000);
    // R3 signed zeros equal
    all_codes(0, 64'h0000_0000, 64'h8000_0000);
    all_codes(1, 64'h8000_0000_0000_0000, 64'h0);
    // R2 R6 quiet and signaling NaN, single and double
    all_codes(0, 64'h7FC0_0000, 64'h3F80_0000);
    all_codes(0, 64'h3F80_0000, 64'h7F80_0001);
    all_codes(1, 64'h7FF8_0000_0000_0000, 64'h1);
    all_codes(1, 64'h0, 64'hFFF0_0000_0000_0001);
    // R4 infinities and double ordering
    all_codes(1, 64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000);
    all_codes(1, 64'hC000_0000_0000_0000, 64'hC000_0000_0000_0001);
    // R7 upper bits must not matter in single format
    all_codes(0, 64'hFFFF_FFFF_3F80_0000, 64'h7FF8_0000_3F80_0000);
    // R8 idle cycles hold outputs
    step(0, 1, 2, 64'h0, 64'h7FF0_0000_0000_0001, 32'h0);
    step(0, 0, 7, 64'h1, 64'h2, 32'hFFFF_FFFF);
    for (int i = 0; i < 3000; i++) begin
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) ra[31:0] = sp[$urandom_range(0, 7)];
      if ($urandom_range(0, 3) == 0) rb[31:0] = sp[$urandom_range(0, 7)];
      if ($urandom_range(0, 7) == 0) rb = ra;
      step($urandom_range(0, 4) != 0, 1'($urandom), int'($urandom_range(0, 7)), ra, rb, $urandom);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule